// File: doc/BRIEF.md
# Hardware Lock Manager with Queued Waiters

This block arbitrates mutual-exclusion locks for a group of cores. It never touches memory. A core sends a request message that carries an operation (acquire or release), its own core number and a lock identifier. A small associative table holds every lock identifier that is currently held, together with its owner. An acquire that finds its lock free takes a table entry and receives a grant. An acquire that finds the lock held by another core joins a per-entry first-in first-out queue and gets no response. The requesting core simply stalls until its grant arrives, so it never has to spin.

When the owner releases a lock, one of two things happens. If any core is queued on that lock, the oldest waiter becomes the owner and is sent a grant. If nobody is waiting, the table entry is freed. Some requests cannot be served: the lock table has no free entry, the queue is full, or the owner asks for its own lock again. Each of these is answered with a retry response. A release from a core that does not own the lock is dropped and raises a one-cycle error pulse.

The block also flags a simple deadlock. This happens when a newly queued core owns a lock that is waited on by the current owner of the lock it now waits for. All responses are registered, so each appears in the cycle after its request.

Top module: `lockmgr_top`

## Requirements
- R1: After reset no lock is held, and rsp_valid, err_release and deadlock are all 0.
- R2: An acquire (req_op=0) of a lock held by nobody, while a table entry is free, makes that core the owner. The cycle after the request shows rsp_valid=1 and rsp_grant=1, with rsp_core and rsp_lock equal to the request's core and lock.
- R3: An acquire of a lock held by a different core, when that lock's queue has room, is queued and produces no response.
- R4: A release (req_op=1) by the owner of a lock with waiters hands ownership to the oldest waiter. The cycle after the request shows a grant to that waiter. Waiters are served in arrival order.
- R5: A release by the owner of a lock with no waiters frees the lock and its table entry, and produces no response. A later acquire of that lock by any core is granted.
- R6: A release from a core that is not the owner, or for a lock that is not held, changes nothing and gives no response. It raises err_release for exactly the following cycle.
- R7: An acquire of a lock that is not held, while all ENTRIES table entries are in use, gets a retry response (rsp_valid=1, rsp_grant=0) the next cycle.
- R8: An acquire of a held lock whose queue already holds QDEPTH waiters gets a retry response the next cycle.
- R9: An acquire by the core that already owns the lock gets a retry response the next cycle, and ownership is unchanged.
- R10: Suppose core A is queued on a lock owned by core B, while B is itself queued on a lock owned by A. Then deadlock is 1 for the one cycle after A's acquire, and A stays queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 1 | 0 = acquire, 1 = release |
| req_core | input | CORE_W | Number of the requesting core |
| req_lock | input | LOCK_W | Lock identifier |
| rsp_valid | output | 1 | A response is present |
| rsp_grant | output | 1 | 1 = grant (acknowledge), 0 = retry |
| rsp_core | output | CORE_W | Core the response is addressed to |
| rsp_lock | output | LOCK_W | Lock the response concerns |
| err_release | output | 1 | One-cycle pulse: dropped release |
| deadlock | output | 1 | One-cycle pulse: two-party wait cycle found |

## Verification
The bench builds the manager with four cores, two table entries and a queue depth of two. With these sizes a full table and a full wait queue can each be reached in only a few requests, so R7 and R8 are exercised directly. Four cores also allow a queue to fill while a spare core probes the owner and non-owner cases. A behavioural model predicts every output on every clock, both through a directed scenario that builds a two-party deadlock and through a long stretch of random requests over three lock identifiers.

// File: rtl/lockmgr_pkg.sv
// Package: shared request and response encodings of the lock manager.
package lockmgr_pkg;
    typedef enum logic {
        OP_ACQUIRE = 1'b0,
        OP_RELEASE = 1'b1
    } lm_op_e;

    typedef enum logic {
        RSP_RETRY = 1'b0,
        RSP_GRANT = 1'b1
    } lm_rsp_e;
endpackage

// File: rtl/lm_lookup.sv
// Module: lm_lookup
// Associative search of the lock table. It reports the entry that holds the
// lock identifier (if any) and the lowest-numbered free entry.
// Assumes: the table never holds one identifier in two valid entries.
module lm_lookup #(
    parameter int ENTRIES = 4,
    parameter int LOCK_W  = 8,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0]              ent_valid,
    input  logic [ENTRIES-1:0][LOCK_W-1:0]  ent_id,
    input  logic [LOCK_W-1:0]               key,
    output logic                            hit,
    output logic [SLOT_W-1:0]               hit_idx,
    output logic                            free_avail,
    output logic [SLOT_W-1:0]               free_idx
);
    logic [ENTRIES-1:0] match;

    // Compare the key against every valid entry.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = ent_valid[g] && (ent_id[g] == key);
        end
    endgenerate

    // Encode the matching entry and pick the lowest free entry.
    always_comb begin
        hit        = 1'b0;
        hit_idx    = '0;
        free_avail = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(i);
            end
            if (!ent_valid[i]) begin
                free_avail = 1'b1;
                free_idx   = SLOT_W'(i);
            end
        end
    end

    // R7: a lock identifier occupies at most one entry.
    assert_unique_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/lm_wait_fifo.sv
// Module: lm_wait_fifo
// Queue of waiting core numbers for one lock entry, kept in arrival order.
// Assumes: push and pop never occur in the same cycle, push only when not
// full, pop only when not empty.
module lm_wait_fifo #(
    parameter int DEPTH  = 4,
    parameter int CORE_W = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CORE_W-1:0] push_core,
    input  logic              pop,
    output logic [CORE_W-1:0] head,
    output logic              empty,
    output logic              full
);
    logic [DEPTH-1:0][CORE_W-1:0] slots;
    logic [PTR_W-1:0]             rd_ptr, wr_ptr;
    logic [CNT_W-1:0]             count;

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // Advance pointers and occupancy on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            count  <= count + 1'b1;
        end else if (pop) begin
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count  <= count - 1'b1;
        end
    end

    // Store the pushed core number.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_core;
    end

    // R8: the manager never pushes into a full queue.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R4: the manager never pops an empty queue.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/lockmgr_top.sv
// Module: lockmgr_top
// Central lock manager. It serves one acquire or release request per cycle.
// Grants and retries leave through a registered response port one cycle
// after the request. Per-entry FIFOs hold waiters. A dropped release and a
// two-party deadlock each raise a one-cycle flag.
// Assumes: a queued core issues no further requests until it is granted.
module lockmgr_top #(
    parameter int NUM_CORES = 8,
    parameter int ENTRIES   = 4,
    parameter int QDEPTH    = 4,
    parameter int LOCK_W    = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int SLOT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [CORE_W-1:0] req_core,
    input  logic [LOCK_W-1:0] req_lock,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [CORE_W-1:0] rsp_core,
    output logic [LOCK_W-1:0] rsp_lock,
    output logic              err_release,
    output logic              deadlock
);
    import lockmgr_pkg::*;

    // Lock table state.
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][LOCK_W-1:0] ent_id;
    logic [ENTRIES-1:0][CORE_W-1:0] ent_owner;

    // Per-core waiting record.
    logic [NUM_CORES-1:0]             wait_vld;
    logic [NUM_CORES-1:0][SLOT_W-1:0] wait_slot;

    // Lookup results.
    logic              hit, free_avail;
    logic [SLOT_W-1:0] hit_idx, free_idx;

    // Queue interface.
    logic [ENTRIES-1:0]             q_push, q_pop, q_empty, q_full;
    logic [ENTRIES-1:0][CORE_W-1:0] q_head;

    // Decisions for this cycle.
    logic              do_alloc, do_push, do_pop, do_free, bad_rel, dl_hit;
    logic              nx_rsp_valid, nx_rsp_grant;
    logic [CORE_W-1:0] nx_rsp_core, cur_owner, hand_core;
    logic              hit_empty, hit_full;

    lm_lookup #(.ENTRIES(ENTRIES), .LOCK_W(LOCK_W)) lookup_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_valid  (ent_valid),
        .ent_id     (ent_id),
        .key        (req_lock),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .free_avail (free_avail),
        .free_idx   (free_idx)
    );

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_q
            assign q_push[g] = do_push && (hit_idx == SLOT_W'(g));
            assign q_pop[g]  = do_pop  && (hit_idx == SLOT_W'(g));
            lm_wait_fifo #(.DEPTH(QDEPTH), .CORE_W(CORE_W)) fifo_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push[g]),
                .push_core (req_core),
                .pop       (q_pop[g]),
                .head      (q_head[g]),
                .empty     (q_empty[g]),
                .full      (q_full[g])
            );
        end
    endgenerate

    assign cur_owner = ent_owner[hit_idx];
    assign hand_core = q_head[hit_idx];
    assign hit_empty = q_empty[hit_idx];
    assign hit_full  = q_full[hit_idx];

    // Two-party cycle: the owner we now wait on itself waits on a lock we own.
    assign dl_hit = wait_vld[cur_owner] && (ent_owner[wait_slot[cur_owner]] == req_core);

    // Decide the table action and the response for the current request.
    always_comb begin
        do_alloc     = 1'b0;
        do_push      = 1'b0;
        do_pop       = 1'b0;
        do_free      = 1'b0;
        bad_rel      = 1'b0;
        nx_rsp_valid = 1'b0;
        nx_rsp_grant = RSP_RETRY;
        nx_rsp_core  = req_core;
        if (req_valid) begin
            if (req_op == OP_ACQUIRE) begin
                if (!hit) begin
                    nx_rsp_valid = 1'b1;
                    if (free_avail) begin
                        do_alloc     = 1'b1;
                        nx_rsp_grant = RSP_GRANT;
                    end
                end else if (cur_owner == req_core || hit_full) begin
                    nx_rsp_valid = 1'b1;
                end else begin
                    do_push = 1'b1;
                end
            end else begin
                if (!hit || cur_owner != req_core) begin
                    bad_rel = 1'b1;
                end else if (hit_empty) begin
                    do_free = 1'b1;
                end else begin
                    do_pop       = 1'b1;
                    nx_rsp_valid = 1'b1;
                    nx_rsp_grant = RSP_GRANT;
                    nx_rsp_core  = hand_core;
                end
            end
        end
    end

    // Update lock table entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_id    <= '0;
            ent_owner <= '0;
        end else if (do_alloc) begin
            ent_valid[free_idx] <= 1'b1;
            ent_id[free_idx]    <= req_lock;
            ent_owner[free_idx] <= req_core;
        end else if (do_free) begin
            ent_valid[hit_idx] <= 1'b0;
        end else if (do_pop) begin
            ent_owner[hit_idx] <= hand_core;
        end
    end

    // Track which entry each queued core waits on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_vld  <= '0;
            wait_slot <= '0;
        end else if (do_push) begin
            wait_vld[req_core]  <= 1'b1;
            wait_slot[req_core] <= hit_idx;
        end else if (do_pop) begin
            wait_vld[hand_core] <= 1'b0;
        end
    end

    // Register responses and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_grant   <= 1'b0;
            rsp_core    <= '0;
            rsp_lock    <= '0;
            err_release <= 1'b0;
            deadlock    <= 1'b0;
        end else begin
            rsp_valid   <= nx_rsp_valid;
            rsp_grant   <= nx_rsp_grant;
            rsp_core    <= nx_rsp_core;
            rsp_lock    <= req_lock;
            err_release <= bad_rel;
            deadlock    <= do_push && dl_hit;
        end
    end

    // Check that a granted core is recorded as owner of the granted lock.
    logic grant_owner_ok;
    always_comb begin
        grant_owner_ok = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_valid[i] && ent_id[i] == rsp_lock && ent_owner[i] == rsp_core)
                grant_owner_ok = 1'b1;
        end
    end

    assert_grant_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> grant_owner_ok);
    assert_err_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_release |-> !rsp_valid);
    assert_dl_queued_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |-> !rsp_valid);
    assert_flags_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_release && deadlock) == 1'b0);
endmodule

// File: tb/lockmgr_tb.sv
// Bench for lockmgr_top: a behavioural reference model predicts every output
// on every clock.
module lockmgr_top_tb_top;
    localparam int NC = 4;
    localparam int NE = 2;
    localparam int QD = 2;
    localparam int LW = 8;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic [LW-1:0] req_lock = '0;
    logic          rsp_valid, rsp_grant, err_release, deadlock;
    logic [CW-1:0] rsp_core;
    logic [LW-1:0] rsp_lock;

    always #2.5 clk = ~clk;

    lockmgr_top #(.NUM_CORES(NC), .ENTRIES(NE), .QDEPTH(QD), .LOCK_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_core(req_core), .req_lock(req_lock), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_core(rsp_core), .rsp_lock(rsp_lock),
        .err_release(err_release), .deadlock(deadlock)
    );

    int errors = 0;
    int checks = 0;

    // Reference model state.
    bit held  [256];
    int owner [256];
    int wq    [256][$];
    int waiting_on [NC];
    int n_held = 0;

    // Expected outputs.
    bit e_valid, e_grant, e_err, e_dl;
    int e_core, e_lock;

    task automatic model(input bit v, input bit op, input int c, input int l);
        int h;
        e_valid = 0; e_grant = 0; e_err = 0; e_dl = 0; e_core = c; e_lock = l;
        if (!v) return;
        if (op == 1'b0) begin
            if (!held[l]) begin
                e_valid = 1;
                if (n_held < NE) begin
                    e_grant = 1; held[l] = 1; owner[l] = c; n_held++;
                end
            end else if (owner[l] == c || wq[l].size() == QD) begin
                e_valid = 1;
            end else begin
                int b;
                b = owner[l];
                if (waiting_on[b] >= 0 && owner[waiting_on[b]] == c) e_dl = 1;
                wq[l].push_back(c);
                waiting_on[c] = l;
            end
        end else begin
            if (!held[l] || owner[l] != c) begin
                e_err = 1;
            end else if (wq[l].size() == 0) begin
                held[l] = 0; n_held--;
            end else begin
                h = wq[l].pop_front();
                owner[l] = h; waiting_on[h] = -1;
                e_valid = 1; e_grant = 1; e_core = h;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit bad;
        checks++;
        bad = (rsp_valid !== e_valid) || (err_release !== e_err) || (deadlock !== e_dl);
        if (e_valid && ((rsp_grant !== e_grant) || (rsp_core !== CW'(e_core)) ||
                        (rsp_lock !== LW'(e_lock))))
            bad = 1;
        if (bad) begin
            errors++;
            $display("FAIL %s: got v=%0b g=%0b c=%0d l=%0d err=%0b dl=%0b exp v=%0b g=%0b c=%0d l=%0d err=%0b dl=%0b",
                     tag, rsp_valid, rsp_grant, rsp_core, rsp_lock, err_release, deadlock,
                     e_valid, e_grant, e_core, e_lock, e_err, e_dl);
        end
    endtask

    // One request cycle: drive, predict, then check after the edge.
    task automatic step(input bit v, input bit op, input int c, input int l, input string tag);
        req_valid = v; req_op = op; req_core = CW'(c); req_lock = LW'(l);
        model(v, op, c, l);
        @(posedge clk);
        #1;
        req_valid = 0;
        compare(tag);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin held[i] = 0; owner[i] = 0; end
        for (int i = 0; i < NC; i++) waiting_on[i] = -1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0, 0, 0, 0, "R1");
        step(1, 0, 0, 5, "R2");   // grant core0
        step(1, 0, 1, 5, "R3");   // queued
        step(1, 0, 2, 5, "R3");   // queued
        step(1, 0, 3, 5, "R8");   // queue full -> retry
        step(1, 0, 0, 5, "R9");   // owner again -> retry
        step(1, 1, 3, 5, "R6");   // non-owner release
        step(0, 0, 0, 0, "R6");   // pulse lasts one cycle
        step(1, 1, 3, 9, "R6");   // release of unheld lock
        step(1, 1, 0, 5, "R4");   // oldest waiter core1
        step(1, 1, 1, 5, "R4");   // then core2
        step(1, 1, 2, 5, "R5");   // free
        step(1, 0, 3, 5, "R5");   // reacquire
        step(1, 0, 0, 7, "R2");
        step(1, 0, 1, 9, "R7");   // table full
        step(1, 0, 3, 7, "R3");   // core3 waits on 7 (owner 0)
        step(1, 0, 0, 5, "R10");  // core0 waits on 5 (owner 3)
        step(0, 0, 0, 0, "R10");
        step(1, 1, 3, 5, "R4");   // handover to core0
        step(1, 1, 0, 7, "R4");   // handover to core3
        step(1, 1, 0, 5, "R5");
        step(1, 1, 3, 7, "R5");
        // Random mix over three locks from cores not currently queued.
        for (int n = 0; n < 600; n++) begin
            int c, l;
            bit op;
            c = $urandom_range(NC - 1);
            if (waiting_on[c] >= 0) begin
                step(0, 0, 0, 0, "R3");
            end else begin
                l = 1 + $urandom_range(2);
                op = ($urandom_range(1) == 1);
                step(1, op, c, l, "R4");
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule